// File: doc/BRIEF.md
# Host-Driven Procedure Sequencer

This block lets a host start a multi-step hardware procedure by writing its number, then poll for the result. The host port is a 32-bit read/write port with two word offsets. Offset 4 holds the procedure number, and writing it starts or restarts that procedure. Offset 0 holds the status word. A status read while the procedure is still unfinished makes the controller evaluate the current step. One cycle at a time, it drives a procedure number and a step index to external step engines, which answer busy, next-step or done, together with a 4-bit result code.

Each next-step answer moves the step index on, and the following step is evaluated in the next cycle. Evaluation ends on a busy or done answer. The outcome is then masked to its host-visible bits, latched and returned. Once a finished status is latched, later reads return it without running the engines again.

Procedures 0 (stop) and 1 (no-op) are resolved inside the block. Slots 2 and 3 are empty. Slots 4 to 12 belong to external engines, and each has its own parameterized last-step index. A cycle counter, restarted at every accepted start, turns an evaluation that ends unfinished after the timeout into a failure.

Top module: `proc_cmd_ctrl`

## Requirements
- R1: After reset, a status read returns 0x40000000 without evaluating any step, and a number read returns 0.
- R2: Status bits are: bit 31 busy, bit 30 done, bit 29 next-step, bits 3:0 result code. Codes are 2 failed, 3 aborted and 4 unsupported. The host sees the internal word ANDed with 0xC000000F, so bit 29 and bits 28:4 always read 0.
- R3: A size-4 write to offset 4 of a supported number stores the number, clears the step index, restarts the timeout counter and sets status to 0x80000000. This also applies when the same procedure is still running, and the next evaluation then starts at step 0.
- R4: A write to offset 4 of a number of 13 or more, or of 2 or 3, sets status to 0x40000004 and leaves the stored number unchanged.
- R5: A status read with bit 30 latched returns the latched word and drives no engine evaluation. Writes to offset 0 have no effect.
- R6: A status read with bit 30 clear evaluates steps, one per cycle, from the stored step index. A next-step answer advances the index. A busy or done answer ends the evaluation, and the masked result is latched and returned with host_ack.
- R7: A next-step answer at the procedure's last step leaves the index unchanged and is reported as busy: bit 31 set and bit 29 clear.
- R8: An evaluation that ends with bit 30 clear, once TIMEOUT_CYC or more cycles have passed since the last start, yields 0x40000002. A done answer in that same evaluation takes precedence over the timeout.
- R9: Procedure 0 finishes as 0x40000003 and procedure 1 as 0x40000000, without evaluating any external step.
- R10: An access with host_size other than 4, or with an offset other than 0 or 4, is acknowledged with host_err=1 and host_rdata=0, and changes no state.
- R11: A size-4 read of offset 4 returns the stored procedure number.
- R12: After a busy answer, the next status read resumes evaluation at the step that answered busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, one cycle; issue only after the previous ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset |
| host_size | input | 3 | Access size in bytes |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_ack |
| host_ack | output | 1 | Access finished, one-cycle pulse |
| host_err | output | 1 | Access rejected, valid with host_ack |
| eng_proc | output | NUM_W | Procedure number under evaluation |
| eng_step | output | STEP_W | Step index under evaluation |
| eng_eval | output | 1 | An external step is evaluated this cycle |
| eng_resp | input | 2 | Step answer: 0 busy, 1 next-step, 2 done, 3 treated as busy |
| eng_code | input | 4 | Result code accompanying the answer |

## Verification
Two functions can meet in the same evaluation: the timeout and the step engine's own answer. The bench holds a procedure busy until the timeout window has passed. It then lets the step answer done, so the evaluation ends with a completion that coincides with an expired counter, and it expects the done status and not the failure code. A second case keeps the engine busy through the same window and expects the failure code. Two further pairs also meet in one cycle and are provoked the same way: a restart issued while a procedure is unfinished, and a saturated step that answers next-step. Each is judged by the first step index the engine sees and by the returned word.

// File: rtl/proc_pkg.sv
package proc_pkg;

    typedef enum logic [1:0] {
        RSP_BUSY = 2'd0,
        RSP_NEXT = 2'd1,
        RSP_DONE = 2'd2,
        RSP_RSVD = 2'd3
    } step_rsp_e;

    typedef enum logic {
        CS_IDLE = 1'b0,
        CS_EVAL = 1'b1
    } ctl_state_e;

    localparam int unsigned RUN_BIT  = 31;
    localparam int unsigned DONE_BIT = 30;
    localparam int unsigned NEXT_BIT = 29;

    localparam logic [31:0] VISIBLE_MASK = 32'hC000_000F;
    localparam logic [31:0] RUN_WORD     = 32'h8000_0000;
    localparam logic [31:0] DONE_WORD    = 32'h4000_0000;

    localparam logic [3:0] CODE_NONE    = 4'd0;
    localparam logic [3:0] CODE_FAILED  = 4'd2;
    localparam logic [3:0] CODE_ABORTED = 4'd3;
    localparam logic [3:0] CODE_UNSUP   = 4'd4;

    // Internal (unmasked) word for one step answer.
    function automatic logic [31:0] raw_word(step_rsp_e rsp, logic [3:0] code);
        logic [31:0] w;
        w = {28'd0, code};
        case (rsp)
            RSP_NEXT: w[NEXT_BIT] = 1'b1;
            RSP_DONE: w[DONE_BIT] = 1'b1;
            default:  w[RUN_BIT]  = 1'b1;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/proc_catalog.sv
module proc_catalog import proc_pkg::*; #(
    parameter int unsigned NUM_PROC = 13,
    parameter int unsigned STEP_W   = 2,
    parameter int unsigned NUM_W    = 4,
    parameter logic [NUM_PROC-1:0]        EMPTY_MASK = '0,
    parameter logic [NUM_PROC*STEP_W-1:0] STEP_LAST  = '0
) (
    input  logic [31:0]       req_num,
    input  logic [NUM_W-1:0]  cur_num,
    output logic              req_ok,
    output logic [STEP_W-1:0] cur_last,
    output logic              cur_builtin,
    output logic [1:0]        builtin_rsp,
    output logic [3:0]        builtin_code
);
    localparam int unsigned SLOTS     = 1 << NUM_W;
    localparam int unsigned BUILTIN_N = 2;

    logic [SLOTS-1:0]  slot_ok;
    logic [STEP_W-1:0] last_tbl [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NUM_PROC) begin : g_real
            assign slot_ok[i]  = ~EMPTY_MASK[i];
            assign last_tbl[i] = STEP_LAST[i*STEP_W +: STEP_W];
        end else begin : g_pad
            assign slot_ok[i]  = 1'b0;
            assign last_tbl[i] = '0;
        end
    end

    always_comb begin
        req_ok       = (req_num < 32'(NUM_PROC)) && slot_ok[req_num[NUM_W-1:0]];
        cur_last     = last_tbl[cur_num];
        cur_builtin  = (32'(cur_num) < 32'(BUILTIN_N));
        builtin_rsp  = RSP_DONE;
        builtin_code = (cur_num == '0) ? CODE_ABORTED : CODE_NONE;
    end

endmodule

// File: rtl/proc_timer.sv
module proc_timer #(
    parameter int unsigned LIMIT = 1000,
    parameter int unsigned CNT_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (32'(cnt_q) < LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (32'(cnt_q) >= LIMIT);

endmodule

// File: rtl/proc_result.sv
module proc_result import proc_pkg::*; (
    input  logic [1:0]  rsp,
    input  logic [3:0]  code,
    input  logic        at_last,
    input  logic        expired,
    output logic        advance,
    output logic [31:0] host_word
);
    logic [31:0] raw;

    always_comb begin
        raw     = raw_word(step_rsp_e'(rsp), code);
        advance = (step_rsp_e'(rsp) == RSP_NEXT) && !at_last;
        // saturated step: report busy, next flag is masked away below
        if (step_rsp_e'(rsp) == RSP_NEXT && at_last) begin
            raw[RUN_BIT] = 1'b1;
        end
        if (!raw[DONE_BIT] && expired) begin
            raw = DONE_WORD | {28'd0, CODE_FAILED};
        end
        host_word = raw & VISIBLE_MASK;
    end

endmodule

// File: rtl/proc_cmd_ctrl.sv
module proc_cmd_ctrl import proc_pkg::*; #(
    parameter int unsigned NUM_PROC    = 13,
    parameter int unsigned STEP_W      = 2,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned TIMEOUT_CYC = 200_000_000,
    parameter logic [NUM_PROC-1:0] EMPTY_MASK = 13'b0_0000_0000_1100,
    parameter logic [NUM_PROC*STEP_W-1:0] STEP_LAST = {
        2'd0, 2'd0, 2'd2, 2'd1, 2'd0, 2'd0, 2'd2,
        2'd2, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0},
    localparam int unsigned NUM_W = $clog2(NUM_PROC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [2:0]        host_size,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_ack,
    output logic              host_err,
    output logic [NUM_W-1:0]  eng_proc,
    output logic [STEP_W-1:0] eng_step,
    output logic              eng_eval,
    input  logic [1:0]        eng_resp,
    input  logic [3:0]        eng_code
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_NUMBER = ADDR_W'(4);
    localparam logic [2:0]        WORD_SIZE  = 3'd4;

    typedef struct packed {
        ctl_state_e        st;
        logic [31:0]       status;
        logic [NUM_W-1:0]  num;
        logic [STEP_W-1:0] step;
        logic [31:0]       rdata;
        logic              ack;
        logic              err;
    } ctl_regs_t;

    localparam ctl_regs_t RST_REGS = '{
        st: CS_IDLE, status: DONE_WORD, num: '0, step: '0,
        rdata: '0, ack: 1'b0, err: 1'b0};

    ctl_regs_t d, q;

    logic              req_ok;
    logic [STEP_W-1:0] cur_last;
    logic              cur_builtin;
    logic [1:0]        builtin_rsp;
    logic [3:0]        builtin_code;
    logic [1:0]        sel_rsp;
    logic [3:0]        sel_code;
    logic              at_last;
    logic              advance;
    logic [31:0]       fin_word;
    logic              expired;
    logic              tmr_restart;

    proc_catalog #(
        .NUM_PROC  (NUM_PROC),
        .STEP_W    (STEP_W),
        .NUM_W     (NUM_W),
        .EMPTY_MASK(EMPTY_MASK),
        .STEP_LAST (STEP_LAST)
    ) u_catalog (
        .req_num     (host_wdata),
        .cur_num     (q.num),
        .req_ok      (req_ok),
        .cur_last    (cur_last),
        .cur_builtin (cur_builtin),
        .builtin_rsp (builtin_rsp),
        .builtin_code(builtin_code)
    );

    proc_timer #(
        .LIMIT(TIMEOUT_CYC),
        .CNT_W(CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(tmr_restart),
        .expired(expired)
    );

    always_comb begin
        sel_rsp  = cur_builtin ? builtin_rsp  : eng_resp;
        sel_code = cur_builtin ? builtin_code : eng_code;
        at_last  = (q.step == cur_last);
    end

    proc_result u_result (
        .rsp      (sel_rsp),
        .code     (sel_code),
        .at_last  (at_last),
        .expired  (expired),
        .advance  (advance),
        .host_word(fin_word)
    );

    always_comb begin
        d           = q;
        d.ack       = 1'b0;
        d.err       = 1'b0;
        tmr_restart = 1'b0;
        unique case (q.st)
            CS_IDLE: begin
                if (host_req) begin
                    if (host_size != WORD_SIZE ||
                        (host_addr != OFS_STATUS && host_addr != OFS_NUMBER)) begin
                        d.ack   = 1'b1;
                        d.err   = 1'b1;
                        d.rdata = '0;
                    end else if (host_we) begin
                        d.ack   = 1'b1;
                        d.rdata = '0;
                        if (host_addr == OFS_NUMBER) begin
                            if (req_ok) begin
                                d.num       = host_wdata[NUM_W-1:0];
                                d.step      = '0;
                                d.status    = RUN_WORD;
                                tmr_restart = 1'b1;
                            end else begin
                                d.status = DONE_WORD | {28'd0, CODE_UNSUP};
                            end
                        end
                    end else if (host_addr == OFS_NUMBER) begin
                        d.ack   = 1'b1;
                        d.rdata = 32'(q.num);
                    end else if (q.status[DONE_BIT]) begin
                        d.ack   = 1'b1;
                        d.rdata = q.status;
                    end else begin
                        d.st = CS_EVAL;
                    end
                end
            end
            CS_EVAL: begin
                if (advance) begin
                    d.step = q.step + 1'b1;
                end else begin
                    d.status = fin_word;
                    d.rdata  = fin_word;
                    d.ack    = 1'b1;
                    d.st     = CS_IDLE;
                end
            end
            default: d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_REGS;
        else        q <= d;
    end

    assign host_rdata = q.rdata;
    assign host_ack   = q.ack;
    assign host_err   = q.err;
    assign eng_proc   = q.num;
    assign eng_step   = q.step;
    assign eng_eval   = (q.st == CS_EVAL) && !cur_builtin;

endmodule

// File: rtl/proc_cmd_ctrl_chk.sv
module proc_cmd_ctrl_chk #(
    parameter int unsigned STEP_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ack,
    input logic              host_err,
    input logic [31:0]       host_rdata,
    input logic              eng_eval,
    input logic [STEP_W-1:0] eng_step
);
    // R2
    next_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> !host_rdata[29]);

    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !host_err) |-> !(host_rdata[31] && host_rdata[30]));

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> (host_ack && host_rdata == 32'd0));

    // R6
    step_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_eval && $past(eng_eval)) |->
            (eng_step == $past(eng_step) ||
             eng_step == STEP_W'($past(eng_step) + 1'b1)));

    // R6
    eval_ends_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_eval) |-> host_ack);

endmodule

bind proc_cmd_ctrl proc_cmd_ctrl_chk #(.STEP_W(STEP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_ack  (host_ack),
    .host_err  (host_err),
    .host_rdata(host_rdata),
    .eng_eval  (eng_eval),
    .eng_step  (eng_step)
);

// File: tb/sim_proc_cmd_ctrl.sv
`timescale 1ns/100ps
module sim_proc_cmd_ctrl;
    localparam int unsigned TMO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [2:0]  host_size = 3'd4;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ack, host_err;
    logic [3:0]  eng_proc;
    logic [1:0]  eng_step;
    logic        eng_eval;
    logic [1:0]  eng_resp;
    logic [3:0]  eng_code;

    logic        hold_en = 1'b0;
    logic [1:0]  hold_step = '0;
    logic [1:0]  fin_rsp = 2'd2;
    logic [3:0]  fin_code = '0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    int         ev_total = 0;
    logic [1:0] ev_first = '0;
    logic [1:0] ev_max = '0;
    logic       ev_prev = 1'b0;

    always #2.5 clk = ~clk;

    proc_cmd_ctrl #(.TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ack(host_ack), .host_err(host_err),
        .eng_proc(eng_proc), .eng_step(eng_step), .eng_eval(eng_eval),
        .eng_resp(eng_resp), .eng_code(eng_code)
    );

    function automatic logic [1:0] tb_last(input logic [3:0] p);
        case (p)
            4'd4, 4'd5, 4'd6, 4'd10: return 2'd2;
            4'd9:                    return 2'd1;
            default:                 return 2'd0;
        endcase
    endfunction

    // step engine stub: next-step until the last step, then the final answer
    always_comb begin
        if (hold_en && eng_step == hold_step) begin
            eng_resp = 2'd0;
            eng_code = 4'd0;
        end else if (eng_step < tb_last(eng_proc)) begin
            eng_resp = 2'd1;
            eng_code = 4'd0;
        end else begin
            eng_resp = fin_rsp;
            eng_code = fin_code;
        end
    end

    always @(negedge clk) begin
        if (eng_eval) begin
            if (!ev_prev) begin
                ev_first <= eng_step;
                ev_max   <= eng_step;
            end else if (eng_step > ev_max) begin
                ev_max <= eng_step;
            end
            ev_total <= ev_total + 1;
        end
        ev_prev <= eng_eval;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic host_op(input logic we, input logic [7:0] a, input logic [2:0] sz,
                           input logic [31:0] wd, output logic [31:0] rd, output logic er);
        int n;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        n = 0;
        while (!host_ack && n < 200) begin
            @(negedge clk);
            n++;
        end
        rd = host_rdata;
        er = host_err;
        if (!host_ack) chk("R6 ack", 32'(host_ack), 32'd1);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] wd);
        logic [31:0] r; logic e;
        host_op(1'b1, a, 3'd4, wd, r, e);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] r; logic e;
        host_op(1'b0, a, 3'd4, 32'd0, r, e);
        chk(tag, r, exp);
    endtask

    initial begin
        int e0;
        logic [31:0] r;
        logic e;
        logic [31:0] bad [6];
        bad = '{32'd2, 32'd3, 32'd13, 32'd14, 32'd255, 32'hFFFF_FFFF};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        e0 = ev_total;
        rd_chk("R1 status", 8'd0, 32'h4000_0000);
        rd_chk("R1 number", 8'd4, 32'd0);
        chk("R1 no eval", 32'(ev_total - e0), 32'd0);

        // R9 built-in procedures
        e0 = ev_total;
        wr(8'd4, 32'd0);
        rd_chk("R9 stop", 8'd0, 32'h4000_0003);
        wr(8'd4, 32'd1);
        rd_chk("R9 nop", 8'd0, 32'h4000_0000);
        chk("R9 no engine", 32'(ev_total - e0), 32'd0);
        rd_chk("R11 number", 8'd4, 32'd1);

        // R4 unsupported numbers
        foreach (bad[i]) begin
            wr(8'd4, bad[i]);
            rd_chk("R4 status", 8'd0, 32'h4000_0004);
            rd_chk("R4 number kept", 8'd4, 32'd1);
        end

        // R6 sweep over every external procedure
        for (int p = 4; p <= 12; p++) begin
            fin_rsp = 2'd2; fin_code = 4'(p);
            wr(8'd4, 32'(p));
            rd_chk("R3 number", 8'd4, 32'(p));
            e0 = ev_total;
            rd_chk("R6 final", 8'd0, 32'h4000_0000 | 32'(p));
            chk("R6 eval cycles", 32'(ev_total - e0), 32'(tb_last(4'(p))) + 32'd1);
            chk("R6 first step", 32'(ev_first), 32'd0);
            chk("R6 last step", 32'(ev_max), 32'(tb_last(4'(p))));
        end

        // R2 masking: busy answer with all code bits set
        fin_rsp = 2'd0; fin_code = 4'hF;
        wr(8'd4, 32'd5);
        rd_chk("R2 busy code", 8'd0, 32'h8000_000F);

        // R12 resume after busy
        fin_rsp = 2'd2; fin_code = 4'd0;
        hold_en = 1'b1; hold_step = 2'd1;
        wr(8'd4, 32'd4);
        rd_chk("R12 held", 8'd0, 32'h8000_0000);
        chk("R12 reached", 32'(ev_max), 32'd1);
        hold_en = 1'b0;
        rd_chk("R12 done", 8'd0, 32'h4000_0000);
        chk("R12 resume step", 32'(ev_first), 32'd1);

        // R3 restart while running
        hold_en = 1'b1;
        wr(8'd4, 32'd4);
        rd_chk("R3 held", 8'd0, 32'h8000_0000);
        wr(8'd4, 32'd4);
        rd_chk("R3 restart status", 8'd0, 32'h8000_0000);
        chk("R3 restart from 0", 32'(ev_first), 32'd0);
        hold_en = 1'b0;
        rd_chk("R3 done", 8'd0, 32'h4000_0000);

        // R5 latched status, offset 0 writes ignored
        fin_code = 4'd7;
        e0 = ev_total;
        rd_chk("R5 latched", 8'd0, 32'h4000_0000);
        wr(8'd0, 32'hFFFF_FFFF);
        rd_chk("R5 write ignored", 8'd0, 32'h4000_0000);
        rd_chk("R5 number", 8'd4, 32'd4);
        chk("R5 no eval", 32'(ev_total - e0), 32'd0);

        // R7 saturated step
        fin_rsp = 2'd1; fin_code = 4'd0;
        wr(8'd4, 32'd7);
        e0 = ev_total;
        rd_chk("R7 sat", 8'd0, 32'h8000_0000);
        chk("R7 one cycle", 32'(ev_total - e0), 32'd1);
        rd_chk("R7 sat again", 8'd0, 32'h8000_0000);
        chk("R7 step held", 32'(ev_first), 32'd0);

        // R8 timeout
        fin_rsp = 2'd2; fin_code = 4'd0;
        hold_en = 1'b1; hold_step = 2'd1;
        wr(8'd4, 32'd9);
        rd_chk("R8 early", 8'd0, 32'h8000_0000);
        repeat (TMO + 10) @(negedge clk);
        rd_chk("R8 timeout", 8'd0, 32'h4000_0002);
        e0 = ev_total;
        rd_chk("R8 latched", 8'd0, 32'h4000_0002);
        chk("R8 no eval", 32'(ev_total - e0), 32'd0);

        // R8 completion in the same evaluation as an expired counter
        wr(8'd4, 32'd9);
        repeat (TMO + 10) @(negedge clk);
        hold_en = 1'b0;
        rd_chk("R8 done wins", 8'd0, 32'h4000_0000);

        // R10 rejected accesses
        host_op(1'b1, 8'd4, 3'd2, 32'd5, r, e);
        chk("R10 write err", 32'(e), 32'd1);
        chk("R10 write rdata", r, 32'd0);
        rd_chk("R10 number kept", 8'd4, 32'd9);
        host_op(1'b0, 8'd0, 3'd1, 32'd0, r, e);
        chk("R10 read err", 32'(e), 32'd1);
        host_op(1'b0, 8'd2, 3'd4, 32'd0, r, e);
        chk("R10 offset err", 32'(e), 32'd1);
        host_op(1'b0, 8'd4, 3'd4, 32'd0, r, e);
        chk("R11 no err", 32'(e), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule